// File: doc/BRIEF.md
# Two-wire bus master with address-prefix phase

This block is a single-master controller for the two-wire serial bus (I2C). Each request moves exactly one data byte to or from a slave. Between the device address and the data byte it can insert a prefix of zero to three address bytes, which selects a location inside the slave, for example a memory word. The block takes its request on a parallel interface: a 7-bit device address, a 24-bit prefix value and a 2-bit prefix length, a direction select, a write byte and a start strobe. It reports busy, a one-cycle done pulse, the received byte and an error flag for an unacknowledged byte.

A write sends the device address, then the prefix, then the data byte. A read with a prefix first sends the device address with the write direction and the prefix. It then turns the bus around with a repeated start and addresses the slave again with the read direction. A read without a prefix addresses the slave for reading straight after the start condition. A slave with a 10-bit address is reached through the prefix mechanism. The device field carries the 11110 marker and the two top address bits, and a one-byte prefix carries the low eight bits.

The bus side has open-drain style enables. A high enable pulls the line low and a low enable releases it. SDA is sampled through the sda_in input. Bus timing is built from quarter-bit periods of QUARTER_CYCLES system clocks.

Top module: `i2cm_ia_master`

## Requirements
- R1: After reset, and at all times while busy is low, scl_oe and sda_oe are both 0 (lines released), and done is 0 after reset.
- R2: A write (rw=0) produces on the bus: start condition, byte {dev_addr,0} acknowledged, the prefix bytes, the wdata byte acknowledged, stop condition. Bytes go MSB first and each is followed by a ninth bit in which SDA low means acknowledge.
- R3: ia_size selects 0, 1, 2 or 3 prefix bytes, sent most significant first: size 3 sends int_addr[23:16], [15:8], [7:0]; size 2 sends [15:8], [7:0]; size 1 sends [7:0]. Each must be acknowledged.
- R4: A read (rw=1) with nonzero ia_size sends start, {dev_addr,0}, the prefix bytes, then a repeated start (SDA falling while SCL is high without an intervening stop), then {dev_addr,1}.
- R5: A read with ia_size 0 sends {dev_addr,1} directly after the start condition, with no repeated start and no {dev_addr,0} byte.
- R6: In a read, the master releases SDA for eight bits and assembles the received bits MSB first into rdata. It answers with NACK (SDA high in the ninth bit) and then a stop, and rdata holds the byte in the cycle done is high.
- R7: A 10-bit slave address A[9:0] is reached with dev_addr = {5'b11110, A[9:8]}, ia_size 1 and int_addr[7:0] = A[7:0]. The first bus byte is then {5'b11110, A[9:8], 0} and the second is A[7:0].
- R8: If the slave does not acknowledge an address, prefix or write-data byte, no further byte is sent. A stop follows, and done is raised with nack_err = 1. Without such a NACK, nack_err is 0 at done.
- R9: SDA changes only while SCL is low, except for the SDA edge of a start, repeated start or stop, which happens while SCL is high. The two enables never change in the same clock cycle.
- R10: Every SCL high pulse that ends with SCL pulled low lasts exactly 2*QUARTER_CYCLES clock cycles.
- R11: busy is high from the cycle after an accepted start strobe until the stop condition has completed. done is a single-cycle pulse raised in the cycle busy falls.
- R12: A start strobe while busy is high is ignored: the transaction in progress finishes unchanged and produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only while not busy |
| rw | input | 1 | Direction: 0 write, 1 read |
| dev_addr | input | 7 | Slave device address |
| int_addr | input | 24 | Address-prefix value |
| ia_size | input | 2 | Number of prefix bytes, 0 to 3 |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte received by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| nack_err | output | 1 | Last transaction ended on a missing acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions check every cycle that the lines are released while idle, that SCL and SDA never switch together, and that SDA moves under a high SCL only during a start, repeated-start or stop step. They also check that done coincides with busy falling and lasts one cycle, that the command issuers never collide at the bit engine, and that a strobe during busy leaves the latched request untouched. Only the bench scenarios, driving a behavioural slave, can show the byte order of each transaction shape: prefix length, the repeated start or its absence, the 10-bit form, the received byte, and where a NACK cuts the sequence. The SCL high-pulse width is measured there too.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   localparam int BYTE_W = 8;

   // bit-level operations executed by the line engine
   typedef enum logic [1:0] {
      OP_START  = 2'd0,
      OP_RSTART = 2'd1,
      OP_STOP   = 2'd2,
      OP_BIT    = 2'd3
   } bus_op_e;

   typedef enum logic [3:0] {
      S_IDLE   = 4'd0,
      S_START  = 4'd1,
      S_DEVW   = 4'd2,
      S_IA     = 4'd3,
      S_RSTART = 4'd4,
      S_DEVR   = 4'd5,
      S_WDATA  = 4'd6,
      S_RDATA  = 4'd7,
      S_STOP   = 4'd8
   } seq_state_e;

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
   parameter int QUARTER_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign tick = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/i2cm_bit_phy.sv
module i2cm_bit_phy
   import i2cm_pkg::*;
#(
   parameter int SDA_SYNC = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    cmd_valid,
   input  bus_op_e cmd_op,
   input  logic    cmd_bit,
   output logic    active,
   output logic    bit_done,
   output logic    rx_bit,
   output logic    scl_oe,
   output logic    sda_oe,
   input  logic    sda_in
);
   bus_op_e    op_q;
   logic       bit_q;
   logic [1:0] ph_q;
   logic [1:0] ph_nx;
   logic       active_q;
   logic       sda_s;
   logic [1:0] rel_first;
   logic [1:0] rel_next;

   // {scl released, sda released} for one quarter of an operation
   function automatic logic [1:0] line_rel(bus_op_e op, logic b, logic [1:0] ph);
      logic [1:0] r;
      case (op)
         OP_START:  r = (ph == 2'd0) ? 2'b11 : (ph == 2'd3) ? 2'b00 : 2'b10;
         OP_RSTART: r = (ph == 2'd0) ? 2'b01 : (ph == 2'd1) ? 2'b11 :
                        (ph == 2'd2) ? 2'b10 : 2'b00;
         OP_STOP:   r = (ph == 2'd0) ? 2'b00 : (ph == 2'd1) ? 2'b10 : 2'b11;
         default:   r = {(ph == 2'd1) || (ph == 2'd2), b};
      endcase
      return r;
   endfunction

   generate
      if (SDA_SYNC != 0) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], sda_in};
         end
         assign sda_s = sync_q[1];
      end else begin : g_direct
         assign sda_s = sda_in;
      end
   endgenerate

   assign ph_nx     = ph_q + 2'd1;
   assign rel_first = line_rel(cmd_op, cmd_bit, 2'd0);
   assign rel_next  = line_rel(op_q, bit_q, ph_nx);
   assign active    = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         op_q     <= OP_STOP;
         bit_q    <= 1'b1;
         ph_q     <= 2'd0;
         bit_done <= 1'b0;
         rx_bit   <= 1'b1;
         scl_oe   <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         bit_done <= 1'b0;
         if (!active_q && cmd_valid) begin
            active_q <= 1'b1;
            op_q     <= cmd_op;
            bit_q    <= cmd_bit;
            ph_q     <= 2'd0;
            scl_oe   <= ~rel_first[1];
            sda_oe   <= ~rel_first[0];
         end else if (active_q && tick) begin
            if (ph_q == 2'd2) rx_bit <= sda_s;
            if (ph_q == 2'd3) begin
               active_q <= 1'b0;
               bit_done <= 1'b1;
            end else begin
               ph_q   <= ph_nx;
               scl_oe <= ~rel_next[1];
               sda_oe <= ~rel_next[0];
            end
         end
      end
   end

   AST_ONE_LINE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!$stable(scl_oe) && !$stable(sda_oe)))
      else $error("both bus lines switched in one cycle"); // R9

   AST_SDA_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(scl_oe)) |-> (op_q != OP_BIT))
      else $error("SDA moved under high SCL in a data bit"); // R9

   AST_CMD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !active_q)
      else $error("command issued to a busy line engine"); // R2

endmodule

// File: rtl/i2cm_byte_shift.sv
module i2cm_byte_shift
   import i2cm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              eng_done,
   input  logic              eng_rx,
   output logic              cmd_valid,
   output logic              cmd_bit,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              ack_n
);
   localparam int SLOTS = BYTE_W + 1;
   localparam int CW    = $clog2(SLOTS + 1);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   logic             run_q;
   logic             wait_q;
   logic [CW-1:0]    cnt_q;
   logic [SLOTS-1:0] sh_q;

   // ninth slot is sent as 1: release for acknowledge, or NACK on a read
   assign cmd_valid = run_q && !wait_q;
   assign cmd_bit   = sh_q[SLOTS-1];
   assign rx_byte   = sh_q[SLOTS-1:1];
   assign ack_n     = sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         wait_q <= 1'b0;
         cnt_q  <= '0;
         sh_q   <= '1;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !run_q) begin
            run_q  <= 1'b1;
            wait_q <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= {tx_byte, 1'b1};
         end else if (run_q) begin
            if (!wait_q) begin
               wait_q <= 1'b1;
            end else if (eng_done) begin
               wait_q <= 1'b0;
               sh_q   <= {sh_q[SLOTS-2:0], eng_rx};
               if (cnt_q == LAST) begin
                  run_q <= 1'b0;
                  done  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !run_q)
      else $error("byte started while a byte is in flight"); // R2

endmodule

// File: rtl/i2cm_txn_seq.sv
module i2cm_txn_seq
   import i2cm_pkg::*;
#(
   parameter int DEV_W        = 7,
   parameter int IA_BYTES_MAX = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start,
   input  logic                                 rw,
   input  logic [DEV_W-1:0]                     dev_addr,
   input  logic [BYTE_W*IA_BYTES_MAX-1:0]       int_addr,
   input  logic [$clog2(IA_BYTES_MAX+1)-1:0]    ia_size,
   input  logic [BYTE_W-1:0]                    wdata,
   input  logic                                 eng_done,
   input  logic                                 byte_done,
   input  logic [BYTE_W-1:0]                    byte_rx,
   input  logic                                 byte_ack_n,
   output logic                                 cond_valid,
   output bus_op_e                              cond_op,
   output logic                                 byte_go,
   output logic [BYTE_W-1:0]                    byte_tx,
   output logic                                 busy,
   output logic                                 done,
   output logic                                 nack_err,
   output logic [BYTE_W-1:0]                    rdata
);
   localparam int SZ_W = $clog2(IA_BYTES_MAX + 1);
   localparam int IA_W = BYTE_W * IA_BYTES_MAX;
   localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(IA_BYTES_MAX);

   seq_state_e        state_q;
   logic              pend_q;
   logic [SZ_W-1:0]   idx_q;
   logic [SZ_W-1:0]   sz_q;
   logic              rw_q;
   logic [DEV_W-1:0]  dev_q;
   logic [IA_W-1:0]   ia_q;
   logic [BYTE_W-1:0] wd_q;
   logic              is_cond;
   logic              is_byte;
   logic              step_done;
   logic              acked;
   logic [SZ_W-1:0]   sz_eff;
   logic [BYTE_W-1:0] ia_b [IA_BYTES_MAX];

   generate
      for (genvar g = 0; g < IA_BYTES_MAX; g++) begin : g_ia_slice
         assign ia_b[g] = ia_q[BYTE_W*g +: BYTE_W];
      end
   endgenerate

   assign sz_eff  = (ia_size > SZ_MAX) ? SZ_MAX : ia_size;
   assign is_cond = (state_q == S_START) || (state_q == S_RSTART) || (state_q == S_STOP);
   assign is_byte = (state_q == S_DEVW) || (state_q == S_DEVR) || (state_q == S_IA) ||
                    (state_q == S_WDATA) || (state_q == S_RDATA);
   assign cond_valid = is_cond && !pend_q;
   assign byte_go    = is_byte && !pend_q;
   assign step_done  = pend_q && (is_cond ? eng_done : byte_done);
   assign acked      = !byte_ack_n;

   always_comb begin
      case (state_q)
         S_START:  cond_op = OP_START;
         S_RSTART: cond_op = OP_RSTART;
         default:  cond_op = OP_STOP;
      endcase
   end

   always_comb begin
      case (state_q)
         S_DEVW:  byte_tx = {dev_q, 1'b0};
         S_DEVR:  byte_tx = {dev_q, 1'b1};
         S_IA:    byte_tx = ia_b[idx_q];
         S_WDATA: byte_tx = wd_q;
         default: byte_tx = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         pend_q   <= 1'b0;
         idx_q    <= '0;
         sz_q     <= '0;
         rw_q     <= 1'b0;
         dev_q    <= '0;
         ia_q     <= '0;
         wd_q     <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         nack_err <= 1'b0;
         rdata    <= '0;
      end else begin
         done <= 1'b0;
         if (state_q == S_IDLE) begin
            if (start) begin
               rw_q     <= rw;
               dev_q    <= dev_addr;
               ia_q     <= int_addr;
               sz_q     <= sz_eff;
               wd_q     <= wdata;
               busy     <= 1'b1;
               nack_err <= 1'b0;
               pend_q   <= 1'b0;
               state_q  <= S_START;
            end
         end else if (!pend_q) begin
            pend_q <= 1'b1;
         end else if (step_done) begin
            pend_q <= 1'b0;
            case (state_q)
               S_START: state_q <= (rw_q && (sz_q == '0)) ? S_DEVR : S_DEVW;
               S_DEVW: begin
                  if (!acked) begin
                     nack_err <= 1'b1;
                     state_q  <= S_STOP;
                  end else if (sz_q != '0) begin
                     idx_q   <= sz_q - 1'b1;
                     state_q <= S_IA;
                  end else begin
                     state_q <= S_WDATA;
                  end
               end
               S_IA: begin
                  if (!acked) begin
                     nack_err <= 1'b1;
                     state_q  <= S_STOP;
                  end else if (idx_q != '0) begin
                     idx_q <= idx_q - 1'b1;
                  end else begin
                     state_q <= rw_q ? S_RSTART : S_WDATA;
                  end
               end
               S_RSTART: state_q <= S_DEVR;
               S_DEVR: begin
                  if (!acked) nack_err <= 1'b1;
                  state_q <= acked ? S_RDATA : S_STOP;
               end
               S_RDATA: begin
                  rdata   <= byte_rx;
                  state_q <= S_STOP;
               end
               S_WDATA: begin
                  if (!acked) nack_err <= 1'b1;
                  state_q <= S_STOP;
               end
               S_STOP: begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  state_q <= S_IDLE;
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(dev_q) && $stable(rw_q) && $stable(ia_q) && $stable(wd_q)))
      else $error("strobe during busy altered the request"); // R12

   AST_ERR_ONLY_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack_err) |-> $past(byte_done && byte_ack_n))
      else $error("error flag raised without a missing acknowledge"); // R8

endmodule

// File: rtl/i2cm_ia_master.sv
module i2cm_ia_master
   import i2cm_pkg::*;
#(
   parameter int QUARTER_CYCLES = 4,
   parameter int SDA_SYNC       = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rw,
   input  logic [6:0]  dev_addr,
   input  logic [23:0] int_addr,
   input  logic [1:0]  ia_size,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   output logic        busy,
   output logic        done,
   output logic        nack_err,
   output logic        scl_oe,
   output logic        sda_oe,
   input  logic        sda_in
);
   localparam int DEV_W        = 7;
   localparam int IA_BYTES_MAX = 3;

   generate
      if (QUARTER_CYCLES < 2) begin : g_bad_quarter
         $error("QUARTER_CYCLES must be at least 2");
      end
      if ((SDA_SYNC != 0) && (SDA_SYNC != 1)) begin : g_bad_sync
         $error("SDA_SYNC must be 0 or 1");
      end
   endgenerate

   logic        tick;
   logic        eng_active;
   logic        eng_done;
   logic        eng_rx;
   logic        cond_valid;
   bus_op_e     cond_op;
   logic        bit_valid;
   logic        bit_val;
   logic        byte_go;
   logic [7:0]  byte_tx;
   logic        byte_done;
   logic [7:0]  byte_rx;
   logic        byte_ack_n;
   logic        eng_valid;
   bus_op_e     eng_op;

   assign eng_valid = cond_valid | bit_valid;
   assign eng_op    = bit_valid ? OP_BIT : cond_op;

   i2cm_qtick #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_qtick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (eng_active),
      .tick  (tick)
   );

   i2cm_bit_phy #(.SDA_SYNC(SDA_SYNC)) u_phy (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cmd_valid (eng_valid),
      .cmd_op    (eng_op),
      .cmd_bit   (bit_val),
      .active    (eng_active),
      .bit_done  (eng_done),
      .rx_bit    (eng_rx),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .sda_in    (sda_in)
   );

   i2cm_byte_shift u_byte (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (byte_go),
      .tx_byte   (byte_tx),
      .eng_done  (eng_done),
      .eng_rx    (eng_rx),
      .cmd_valid (bit_valid),
      .cmd_bit   (bit_val),
      .done      (byte_done),
      .rx_byte   (byte_rx),
      .ack_n     (byte_ack_n)
   );

   i2cm_txn_seq #(.DEV_W(DEV_W), .IA_BYTES_MAX(IA_BYTES_MAX)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rw         (rw),
      .dev_addr   (dev_addr),
      .int_addr   (int_addr),
      .ia_size    (ia_size),
      .wdata      (wdata),
      .eng_done   (eng_done),
      .byte_done  (byte_done),
      .byte_rx    (byte_rx),
      .byte_ack_n (byte_ack_n),
      .cond_valid (cond_valid),
      .cond_op    (cond_op),
      .byte_go    (byte_go),
      .byte_tx    (byte_tx),
      .busy       (busy),
      .done       (done),
      .nack_err   (nack_err),
      .rdata      (rdata)
   );

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe))
      else $error("bus driven while idle"); // R1

   AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done)
      else $error("busy fell without done"); // R11

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle"); // R11

   AST_ONE_ISSUER: assert property (@(posedge clk) disable iff (!rst_n)
      !(cond_valid && bit_valid))
      else $error("condition and bit issued together"); // R9

endmodule

// File: tb/i2cm_ia_master_tb.sv
module i2cm_ia_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 3;
   localparam int EV_START   = 1000;
   localparam int EV_RSTART  = 1001;
   localparam int EV_STOP    = 1002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rw = 1'b0;
   logic [6:0]  dev_addr = '0;
   logic [23:0] int_addr = '0;
   logic [1:0]  ia_size = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        busy, done, nack_err, scl_oe, sda_oe;
   logic        slv_low = 1'b0;
   wire         scl_line = ~scl_oe;
   wire         sda_line = ~(sda_oe | slv_low);

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int exp_q[$];
   string cur_tag = "R1";

   // slave configuration and state
   int       slv_nack_idx = -1;
   logic [7:0] slv_rdata = '0;
   int       slv_k = 0;
   int       bitcnt = 0;
   logic [7:0] slv_sh = '0;
   logic     slv_ack = 1'b0;
   bit       slv_tx = 0;
   bit       first_byte = 0;
   bit       in_txn = 0;
   logic     prev_scl = 1'b1;
   logic     prev_sda = 1'b1;
   bit       hi_valid = 0;
   int       rise_cyc = 0;
   int       done_cnt = 0;

   i2cm_ia_master #(.QUARTER_CYCLES(Q), .SDA_SYNC(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .dev_addr(dev_addr),
      .int_addr(int_addr), .ia_size(ia_size), .wdata(wdata), .rdata(rdata),
      .busy(busy), .done(done), .nack_err(nack_err), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .sda_in(sda_line)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic got_event(input int ev);
      if (exp_q.size() == 0) begin
         check(0, cur_tag, "unexpected bus event", ev, -1);
      end else begin
         int e = exp_q.pop_front();
         check(ev == e, cur_tag, "bus event", ev, e);
      end
   endtask

   // behavioural slave and bus monitor, evaluated every clock
   always @(negedge clk) begin
      logic s, d;
      cycles++;
      s = scl_line;
      d = sda_line;
      if (done) done_cnt++;
      if (rst_n && !busy)
         check(!scl_oe && !sda_oe, "R1", "lines released while idle", {scl_oe, sda_oe}, 0);
      if (s && prev_scl && prev_sda && !d) begin
         got_event(in_txn ? EV_RSTART : EV_START);
         in_txn = 1; bitcnt = 0; first_byte = 1; slv_tx = 0; slv_low = 1'b0;
      end else if (s && prev_scl && !prev_sda && d) begin
         got_event(EV_STOP);
         in_txn = 0; slv_low = 1'b0; hi_valid = 0;
      end else if (s && !prev_scl) begin
         hi_valid = 1; rise_cyc = cycles;
         if (bitcnt < 8) begin
            slv_sh = {slv_sh[6:0], d};
            bitcnt++;
         end else if (bitcnt == 8) begin
            slv_ack = d;
            got_event({23'd0, slv_ack, slv_sh});
            bitcnt = 9;
         end
      end else if (!s && prev_scl) begin
         if (hi_valid)
            check(cycles - rise_cyc == 2*Q, "R10", "SCL high width", cycles - rise_cyc, 2*Q);
         hi_valid = 0;
         if (bitcnt == 8) begin
            slv_low = slv_tx ? 1'b0 : (slv_k != slv_nack_idx);
         end else if (bitcnt == 9) begin
            bitcnt = 0;
            slv_k++;
            if (slv_tx) slv_tx = 0;
            else if (first_byte && slv_sh[0] && !slv_ack) slv_tx = 1;
            first_byte = 0;
            slv_low = slv_tx ? ~slv_rdata[7] : 1'b0;
         end else if (bitcnt >= 1 && bitcnt <= 7) begin
            slv_low = slv_tx ? ~slv_rdata[7-bitcnt] : 1'b0;
         end
      end
      prev_scl = s;
      prev_sda = d;
   end

   task automatic exp_byte(input int v, inout int k, inout bit ab);
      if (ab) return;
      if (k == slv_nack_idx) begin
         exp_q.push_back(v | 256);
         ab = 1;
      end else begin
         exp_q.push_back(v);
      end
      k++;
   endtask

   task automatic run_txn(input string tag, input bit r, input logic [6:0] dev,
                          input logic [23:0] ia, input int sz, input logic [7:0] wd,
                          input int nack_idx, input logic [7:0] srd, input bit poke);
      int k = 0;
      bit ab = 0;
      int waited = 0;
      cur_tag = tag;
      slv_nack_idx = nack_idx;
      slv_rdata = srd;
      slv_k = 0;
      done_cnt = 0;
      exp_q.delete();
      exp_q.push_back(EV_START);
      if (r && sz == 0) begin
         exp_byte({24'd0, dev, 1'b1}, k, ab);
      end else begin
         exp_byte({24'd0, dev, 1'b0}, k, ab);
         for (int i = sz - 1; i >= 0; i--) exp_byte({24'd0, ia[8*i +: 8]}, k, ab);
         if (r && !ab) begin
            exp_q.push_back(EV_RSTART);
            exp_byte({24'd0, dev, 1'b1}, k, ab);
         end
      end
      if (!ab) begin
         if (r) exp_q.push_back({23'd0, 1'b1, srd});
         else   exp_byte({24'd0, wd}, k, ab);
      end
      exp_q.push_back(EV_STOP);

      @(negedge clk);
      rw = r; dev_addr = dev; int_addr = ia; ia_size = 2'(sz); wdata = wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R11", "busy after strobe", busy, 1);
      if (poke) begin
         repeat (40) @(negedge clk);
         check(busy == 1'b1, "R12", "busy at second strobe", busy, 1);
         rw = ~r; dev_addr = ~dev; int_addr = ~ia; ia_size = 2'd3; wdata = ~wd; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      check(done == 1'b1, tag, "done seen", done, 1);
      check(busy == 1'b0, "R11", "busy low with done", busy, 0);
      check(nack_err == (nack_idx >= 0 && nack_idx < k + 1 && ab), "R8", "nack_err at done",
            nack_err, (ab ? 1 : 0));
      if (r && !ab) check(rdata == srd, "R6", "read data", rdata, srd);
      @(negedge clk);
      check(done == 1'b0, "R11", "done one cycle", done, 0);
      repeat (30) @(negedge clk);
      check(exp_q.size() == 0, tag, "missing bus events", exp_q.size(), 0);
      check(done_cnt == 1, poke ? "R12" : "R11", "done pulses", done_cnt, 1);
      check(!scl_oe && !sda_oe, "R1", "released after stop", {scl_oe, sda_oe}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0, "R1", "status in reset", {busy, done}, 0);
      check(!scl_oe && !sda_oe, "R1", "lines in reset", {scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(busy == 0 && done == 0, "R1", "status after reset", {busy, done}, 0);

      run_txn("R2", 0, 7'h50, 24'h0, 0, 8'h3C, -1, 8'h00, 0);
      run_txn("R3", 0, 7'h2A, 24'hA1B2C3, 3, 8'h96, -1, 8'h00, 0);
      run_txn("R3", 0, 7'h11, 24'h005A0F, 2, 8'h01, -1, 8'h00, 0);
      run_txn("R4", 1, 7'h50, 24'hFF1234, 2, 8'h00, -1, 8'hC5, 0);
      run_txn("R4", 1, 7'h3C, 24'h8E7D6C, 3, 8'h00, -1, 8'h0F, 0);
      run_txn("R5", 1, 7'h33, 24'h0, 0, 8'h00, -1, 8'h5A, 0);
      // 10-bit address 0x2D7: device field 11110_10, prefix 0xD7
      run_txn("R7", 1, 7'h7A, 24'h0000D7, 1, 8'h00, -1, 8'hE1, 0);
      run_txn("R7", 0, 7'h7A, 24'h0000D7, 1, 8'h44, -1, 8'h00, 0);
      run_txn("R8", 0, 7'h2A, 24'hA1B2C3, 3, 8'h96, 2, 8'h00, 0);
      run_txn("R8", 1, 7'h21, 24'h000010, 1, 8'h00, 0, 8'h99, 0);
      run_txn("R8", 0, 7'h21, 24'h000010, 1, 8'h77, 2, 8'h00, 0);
      run_txn("R8", 1, 7'h21, 24'h000010, 1, 8'h00, 2, 8'h99, 0);
      run_txn("R12", 0, 7'h55, 24'h00BEEF, 2, 8'hA5, -1, 8'h00, 1);
      run_txn("R2", 0, 7'h55, 24'h0, 0, 8'hFF, -1, 8'h00, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule